// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a byte-stream sink. Software builds a ring of 8-byte descriptors in memory, programs the ring start address, sets the enable bit of the control register and then pulses the activate input. The engine fetches descriptors one by one, reads each referenced buffer through a simple 32-bit word memory port and sends the bytes out on a valid/ready stream. After each buffer it writes the descriptor back with the ownership bit cleared, and it signals the progress through one-cycle event pulses.

A frame may span several buffers. The buffer whose last flag is set closes the frame, and its final byte carries the stream's last marker. A wrap flag sends the next fetch back to the ring start. The accumulated frame length is limited to MAX_FRAME bytes (2032 by default). Beyond that limit, data is dropped and a babbling-transmit event is raised. The walk stops at the first descriptor software has not handed over. The descriptor pointer is kept, so the next activation continues from that point.

Stream rules: a byte is transferred on a rising edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` low, `tx_data` and `tx_last` hold steady. The sink may hold `tx_ready` low for any number of cycles. Memory rules: a request completes on an edge where `mem_req` and `mem_ready` are both high, and read data is taken from `mem_rdata` on that edge. The address, direction and write data hold until then, except in a cycle where the ring start is written.

Top module: `txr_engine`

## Requirements
- R1: After reset, `busy`, `mem_req`, `tx_valid` and all event outputs are low, the enable bit is clear and the descriptor pointer is 0.
- R2: A control write sets the enable bit from `ctrl_wdata[1]`. `kick` starts a walk only when the enable bit is set and the engine is idle; otherwise it causes no memory access.
- R3: A descriptor holds a flags half-word in bits 31:16 and a byte length in bits 15:0 of the word at the pointer, and the buffer byte address in the word at pointer+4. Flag bit 15 (ready) marks a hardware-owned descriptor. A descriptor read with bit 15 clear ends the walk and is not written back.
- R4: Buffer bytes are sent in ascending address order from any byte alignment. The byte at a word offset of 0 sits in bits 31:24 of the memory word.
- R5: `tx_last` is high only on the final byte of a buffer whose flag bit 11 (last) is set. Buffers without it continue the same frame.
- R6: After each buffer the word at the pointer is rewritten with flag bit 15 cleared, the other flags kept and the length field unchanged. The write is followed by an `ev_txb` pulse, and also an `ev_txf` pulse when flag bit 11 is set. Both pulses come one cycle after the write is accepted.
- R7: After the write-back, the pointer moves to pointer+8, or to the ring start when flag bit 13 (wrap) is set.
- R8: If a buffer would take the frame beyond MAX_FRAME bytes, only the bytes up to the limit are sent, and `ev_babt` pulses once for that buffer. A last buffer clears the frame's byte count.
- R9: A ring start write stores `base_wdata` with bits 1:0 forced to 0 and loads it into the descriptor pointer. If it falls in the same cycle as a pointer advance, the write wins.
- R10: The pointer is kept between walks and across an abort, so the next activation fetches from where the walk stopped.
- R11: A control write with bit 0 set, or with bit 1 clear, aborts the walk on the next edge. The engine goes idle with `busy`, `mem_req` and `tx_valid` low and the frame byte count cleared. A bit 0 write also leaves enable clear.
- R12: Stream outputs hold while stalled by `tx_ready`. A pending memory request holds its address, direction and write data until `mem_ready`, unless the ring start is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 2 | Bit 1 enable, bit 0 reset/abort |
| base_we | input | 1 | Ring start write strobe |
| base_wdata | input | 32 | Ring start byte address |
| kick | input | 1 | Transmit activate pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| ev_txb | output | 1 | Buffer done pulse |
| ev_txf | output | 1 | Frame done pulse |
| ev_babt | output | 1 | Frame length limit hit pulse |
| busy | output | 1 | Walk in progress |

## Verification
A ring start write can arrive in the same cycle as the pointer advance that follows a write-back, and the two compete for the descriptor pointer. The bench waits with the memory always ready until the write-back request is on the bus, then drives the ring start write for that same edge. The next descriptor fetch must go to the new start, the slot after the finished descriptor must not be read, and only one buffer event may be counted. An abort that lands while the sink is stalling a byte is a second such case: the engine must go idle at once, skip the write-back and then resend the whole frame when activated again.

// File: rtl/txr_pkg.sv
package txr_pkg;

  // descriptor layout: flags half-word above the length half-word
  localparam int FW = 16;
  localparam int LW = 16;

  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HEAD,
    S_ADDR,
    S_WORD,
    S_EMIT,
    S_BACK
  } txr_state_e;

endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] cur_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

  logic [AW-1:0] base_q;
  logic [AW-1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      base_q <= load_val & ALIGN_MASK;
      cur_q  <= load_val & ALIGN_MASK;
    end else if (adv) begin
      cur_q <= wrap ? base_q : cur_q + AW'(STEP);
    end
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/txr_len_clip.sv
module txr_len_clip #(
  parameter int LW        = 16,
  parameter int ACCW      = 11,
  parameter int MAX_FRAME = 2032
) (
  input  logic [ACCW-1:0] acc_i,
  input  logic [LW-1:0]   len_i,
  output logic [LW-1:0]   eff_o,
  output logic            over_o
);
  localparam int SW = ((LW > ACCW) ? LW : ACCW) + 1;

  logic [SW-1:0] sum;
  logic [SW-1:0] room;

  always_comb begin
    sum    = SW'(len_i) + SW'(acc_i);
    room   = SW'(MAX_FRAME) - SW'(acc_i);
    over_o = (sum > SW'(MAX_FRAME));
    eff_o  = over_o ? room[LW-1:0] : len_i;
  end

endmodule

// File: rtl/txr_byte_lane.sv
module txr_byte_lane #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]          word_i,
  input  logic [$clog2(DW/8)-1:0] sel_i,
  output logic [7:0]             byte_o
);
  localparam int NB = DW / 8;

  logic [7:0] lanes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    // lowest address offset sits in the most significant byte
    assign lanes[g] = word_i[DW-1-8*g -: 8];
  end

  assign byte_o = lanes[sel_i];

endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int DW        = 32,
  parameter int MAX_FRAME = 2032,
  parameter int DESC_STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [1:0]    ctrl_wdata,
  input  logic          base_we,
  input  logic [DW-1:0] base_wdata,
  input  logic          kick,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          ev_txb,
  output logic          ev_txf,
  output logic          ev_babt,
  output logic          busy
);
  localparam int NB   = DW / 8;
  localparam int SELW = $clog2(NB);
  localparam int ACCW = $clog2(MAX_FRAME + 1);
  localparam logic [DW-1:0] WORD_MASK = ~DW'(NB - 1);
  localparam logic [FW-1:0] CLR_READY = ~(FW'(1) << FLG_READY);

  txr_state_e      state;
  logic            enable_q;
  logic [FW-1:0]   flags_q;
  logic [LW-1:0]   len_q;
  logic [LW-1:0]   remain;
  logic [DW-1:0]   baddr;
  logic [DW-1:0]   word_q;
  logic [ACCW-1:0] acc;

  logic [DW-1:0]   cur_ptr;
  logic [LW-1:0]   eff_len;
  logic            clip_over;
  logic            abort;
  logic            ptr_adv;

  assign abort   = ctrl_we && (ctrl_wdata[0] || !ctrl_wdata[1]);
  assign ptr_adv = (state == S_BACK) && mem_ready && !abort;

  txr_ring_ptr #(.AW(DW), .STEP(DESC_STEP)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (base_we),
    .load_val (base_wdata),
    .adv      (ptr_adv),
    .wrap     (flags_q[FLG_WRAP]),
    .cur_o    (cur_ptr)
  );

  txr_len_clip #(.LW(LW), .ACCW(ACCW), .MAX_FRAME(MAX_FRAME)) u_clip (
    .acc_i  (acc),
    .len_i  (len_q),
    .eff_o  (eff_len),
    .over_o (clip_over)
  );

  txr_byte_lane #(.DW(DW)) u_lane (
    .word_i (word_q),
    .sel_i  (baddr[SELW-1:0]),
    .byte_o (tx_data)
  );

  always_comb begin
    mem_req   = (state == S_HEAD) || (state == S_ADDR) ||
                (state == S_WORD) || (state == S_BACK);
    mem_we    = (state == S_BACK);
    mem_wdata = {flags_q & CLR_READY, len_q};
    unique case (state)
      S_ADDR:  mem_addr = cur_ptr + DW'(4);
      S_WORD:  mem_addr = baddr & WORD_MASK;
      default: mem_addr = cur_ptr;
    endcase
  end

  assign tx_valid = (state == S_EMIT);
  assign tx_last  = (state == S_EMIT) && flags_q[FLG_LAST] && (remain == LW'(1));
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      enable_q <= 1'b0;
      flags_q  <= '0;
      len_q    <= '0;
      remain   <= '0;
      baddr    <= '0;
      word_q   <= '0;
      acc      <= '0;
      ev_txb   <= 1'b0;
      ev_txf   <= 1'b0;
      ev_babt  <= 1'b0;
    end else begin
      ev_txb  <= 1'b0;
      ev_txf  <= 1'b0;
      ev_babt <= 1'b0;
      if (ctrl_we) enable_q <= ctrl_wdata[1] & ~ctrl_wdata[0];
      if (abort) begin
        state <= S_IDLE;
        acc   <= '0;
      end else begin
        unique case (state)
          S_IDLE: if (kick && enable_q) state <= S_HEAD;
          S_HEAD: if (mem_ready) begin
            if (!mem_rdata[LW+FLG_READY]) begin
              state <= S_IDLE;
            end else begin
              flags_q <= mem_rdata[DW-1 -: FW];
              len_q   <= mem_rdata[LW-1:0];
              state   <= S_ADDR;
            end
          end
          S_ADDR: if (mem_ready) begin
            baddr   <= mem_rdata;
            remain  <= eff_len;
            acc     <= acc + ACCW'(eff_len);
            ev_babt <= clip_over;
            state   <= (eff_len == '0) ? S_BACK : S_WORD;
          end
          S_WORD: if (mem_ready) begin
            word_q <= mem_rdata;
            state  <= S_EMIT;
          end
          S_EMIT: if (tx_ready) begin
            baddr  <= baddr + DW'(1);
            remain <= remain - LW'(1);
            if (remain == LW'(1))                state <= S_BACK;
            else if (baddr[SELW-1:0] == '1)      state <= S_WORD;
          end
          S_BACK: if (mem_ready) begin
            ev_txb <= 1'b1;
            ev_txf <= flags_q[FLG_LAST];
            if (flags_q[FLG_LAST]) acc <= '0;
            state  <= S_HEAD;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !enable_q) |=> !mem_req); // R2

  AST_WB_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[LW+FLG_READY]); // R6

  AST_FRAME_WITH_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txf |-> ev_txb); // R6

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && !abort) |=> !tx_valid); // R5

  AST_FRAME_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= ACCW'(MAX_FRAME)); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[0]) |=> (!busy && !mem_req && !tx_valid)); // R11

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !abort) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_last))); // R12

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !abort && !base_we) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

endmodule

// File: tb/sim_txr_engine.sv
module sim_txr_engine;

  typedef struct packed {
    logic [11:0] la;
    logic [11:0] lb;
    logic [1:0]  oa;
    logic [1:0]  ob;
    logic        ms;
    logic        ts;
    logic [11:0] exp_n;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{12'd5, 12'd3, 2'd0, 2'd1, 1'b0, 1'b0, 12'd8},
    '{12'd1, 12'd7, 2'd3, 2'd2, 1'b1, 1'b0, 12'd8},
    '{12'd9, 12'd4, 2'd2, 2'd3, 1'b0, 1'b1, 12'd13},
    '{12'd6, 12'd1, 2'd1, 2'd0, 1'b1, 1'b1, 12'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [1:0]  ctrl_wdata;
  logic        base_we;
  logic [31:0] base_wdata;
  logic        kick;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;
  logic        ev_txb, ev_txf, ev_babt, busy;

  always #10 clk = ~clk;

  txr_engine u0 (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .base_we(base_we), .base_wdata(base_wdata),
    .kick(kick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]};
  endfunction

  function automatic logic [31:0] pat_word(input logic [31:0] a);
    logic [31:0] w;
    w = a & ~32'd3;
    return {pat(w), pat(w + 1), pat(w + 2), pat(w + 3)};
  endfunction

  // memory and sink model
  logic [31:0] dmem [256];
  logic [31:0] cyc = '0;
  logic        mstall = 1'b0, tstall = 1'b0;
  logic [7:0]  rx_byte [4096];
  bit          rx_last [4096];
  int rx_n, n_txb, n_txf, n_babt, head_cnt, mem_cnt, wb_cnt, hold_bad;
  logic [31:0] last_head, first_head;
  bit          hold_pend;
  logic [7:0]  hold_d;
  bit          hold_l;

  assign mem_ready = !mstall || cyc[1];
  assign tx_ready  = !tstall || (cyc[0] ^ cyc[2]);
  always_comb mem_rdata = (mem_addr < 32'h400) ? dmem[mem_addr[9:2]] : pat_word(mem_addr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mem_req && mem_ready) begin
        mem_cnt++;
        if (mem_we) begin
          if (mem_addr < 32'h400) dmem[mem_addr[9:2]] = mem_wdata;
          wb_cnt++;
        end else if (mem_addr < 32'h400 && !mem_addr[2]) begin
          if (head_cnt == 0) first_head = mem_addr;
          head_cnt++;
          last_head = mem_addr;
        end
      end
      if (hold_pend && (!tx_valid || tx_data != hold_d || tx_last != hold_l)) hold_bad++;
      hold_pend = tx_valid && !tx_ready && !ctrl_we;
      hold_d    = tx_data;
      hold_l    = tx_last;
      if (tx_valid && tx_ready) begin
        rx_byte[rx_n] = tx_data;
        rx_last[rx_n] = tx_last;
        rx_n++;
      end
      if (ev_txb)  n_txb++;
      if (ev_txf)  n_txf++;
      if (ev_babt) n_babt++;
    end
  end

  task automatic clr();
    rx_n = 0; n_txb = 0; n_txf = 0; n_babt = 0;
    head_cnt = 0; mem_cnt = 0; wb_cnt = 0;
    first_head = 32'hFFFF_FFFF; last_head = 32'hFFFF_FFFF;
  endtask

  task automatic ctrl(input logic [1:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic setbase(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic chk_bytes(input int start, input logic [31:0] addr, input int n,
                           input bit last_end, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (rx_byte[start + i] !== pat(addr + i)) bad++;
      if (rx_last[start + i] != (last_end && i == n - 1)) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] ptr, ba, bb;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; base_we = 1'b0;
    base_wdata = '0; kick = 1'b0;
    hold_pend = 0; hold_bad = 0;
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !mem_req && !tx_valid, "R1 outputs idle after reset", {busy, mem_req, tx_valid}, 0);
    chk(!ev_txb && !ev_txf && !ev_babt, "R1 events low after reset", {ev_txb, ev_txf, ev_babt}, 0);

    // R2 kick while disabled
    dmem[0] = {16'h8800, 16'd4};
    clr(); go(); repeat (5) @(negedge clk);
    chk(mem_cnt == 0 && !busy, "R2 kick ignored while disabled", mem_cnt, 0);

    ctrl(2'b10);

    // table-driven frames of two buffers
    ptr = 32'h0;
    for (int vi = 0; vi < NVEC; vi++) begin
      ba = 32'h1000 + vi * 32'h100 + 32'(VECS[vi].oa);
      bb = 32'h2000 + vi * 32'h100 + 32'(VECS[vi].ob);
      dmem[ptr[9:2]]     = {16'h8000, 4'h0, VECS[vi].la};
      dmem[ptr[9:2] + 1] = ba;
      dmem[ptr[9:2] + 2] = {16'h8800, 4'h0, VECS[vi].lb};
      dmem[ptr[9:2] + 3] = bb;
      dmem[ptr[9:2] + 4] = '0;
      mstall = VECS[vi].ms; tstall = VECS[vi].ts;
      clr(); go(); wait_idle();
      if (vi == 0) chk(first_head == 32'h0, "R1 pointer starts at zero", first_head, 0);
      else chk(first_head == ptr, "R10 walk resumes at stop point", first_head, ptr);
      chk(rx_n == int'(VECS[vi].exp_n), "R4 byte count", rx_n, VECS[vi].exp_n);
      chk_bytes(0, ba, int'(VECS[vi].la), 1'b0, "R4 first buffer bytes");
      chk_bytes(int'(VECS[vi].la), bb, int'(VECS[vi].lb), 1'b1, "R5 second buffer bytes and last");
      chk(n_txb == 2 && n_txf == 1, "R6 event counts", n_txb * 10 + n_txf, 21);
      chk(dmem[ptr[9:2]] == {16'h0000, 4'h0, VECS[vi].la} &&
          dmem[ptr[9:2] + 2] == {16'h0800, 4'h0, VECS[vi].lb},
          "R6 write-back clears ready", dmem[ptr[9:2] + 2], {16'h0800, 4'h0, VECS[vi].lb});
      chk(last_head == ptr + 16 && head_cnt == 3, "R3 stop at unready descriptor", last_head, ptr + 16);
      chk(wb_cnt == 2, "R3 unready descriptor not written", wb_cnt, 2);
      ptr = ptr + 16;
    end
    mstall = 1'b0; tstall = 1'b0;

    // wrap to ring start
    dmem[32'h300 >> 2]       = {16'h8000, 16'd2};
    dmem[(32'h300 >> 2) + 1] = 32'h3000;
    dmem[32'h308 >> 2]       = {16'hA800, 16'd2};
    dmem[(32'h308 >> 2) + 1] = 32'h3101;
    setbase(32'h303);
    clr(); go(); wait_idle();
    chk(first_head == 32'h300, "R9 ring start drops low bits", first_head, 32'h300);
    chk(last_head == 32'h300 && head_cnt == 3, "R7 wrap returns to ring start", last_head, 32'h300);
    chk(rx_n == 4, "R7 wrap frame bytes", rx_n, 4);
    chk_bytes(2, 32'h3101, 2, 1'b1, "R7 wrap buffer data");

    // frame length limit
    dmem[32'h200 >> 2] = {16'h8000, 16'd2000}; dmem[(32'h200 >> 2) + 1] = 32'h4000;
    dmem[32'h208 >> 2] = {16'h8800, 16'd100};  dmem[(32'h208 >> 2) + 1] = 32'h5000;
    dmem[32'h210 >> 2] = {16'h8800, 16'd5};    dmem[(32'h210 >> 2) + 1] = 32'h6000;
    dmem[32'h218 >> 2] = '0;
    setbase(32'h200);
    clr(); go(); wait_idle();
    chk(rx_n == 2037, "R8 bytes with clipped frame", rx_n, 2037);
    chk_bytes(0, 32'h4000, 2000, 1'b0, "R8 first buffer");
    chk_bytes(2000, 32'h5000, 32, 1'b1, "R8 clipped buffer ends frame");
    chk_bytes(2032, 32'h6000, 5, 1'b1, "R8 next frame not clipped");
    chk(n_babt == 1, "R8 babble event once", n_babt, 1);
    chk(n_txb == 3 && n_txf == 2, "R8 events on clipped walk", n_txb * 10 + n_txf, 32);
    chk(dmem[32'h208 >> 2] == {16'h0800, 16'd100}, "R8 write-back keeps length", dmem[32'h208 >> 2], {16'h0800, 16'd100});

    // ring start write in the advance cycle
    dmem[32'h100 >> 2] = {16'h8800, 16'd1}; dmem[(32'h100 >> 2) + 1] = 32'h7000;
    dmem[32'h108 >> 2] = {16'h8800, 16'd1}; dmem[(32'h108 >> 2) + 1] = 32'h7100;
    dmem[32'h180 >> 2] = '0;
    setbase(32'h100);
    clr(); go();
    for (int i = 0; i < 100; i++) begin
      if (mem_req && mem_we) break;
      @(negedge clk);
    end
    base_we = 1'b1; base_wdata = 32'h181;
    @(negedge clk); base_we = 1'b0;
    wait_idle();
    chk(last_head == 32'h180 && head_cnt == 2, "R9 ring start write beats advance", last_head, 32'h180);
    chk(n_txb == 1, "R9 one buffer done", n_txb, 1);
    chk(dmem[32'h108 >> 2][31:16] == 16'h8800, "R9 skipped slot untouched", dmem[32'h108 >> 2][31:16], 16'h8800);

    // abort mid-frame
    dmem[32'h40 >> 2] = {16'h8800, 16'd200}; dmem[(32'h40 >> 2) + 1] = 32'h8000;
    dmem[32'h48 >> 2] = '0;
    setbase(32'h40);
    tstall = 1'b1;
    clr(); go(); repeat (30) @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 2'b01;
    @(negedge clk); ctrl_we = 1'b0;
    chk(!busy && !tx_valid && !mem_req, "R11 abort returns to idle", {busy, tx_valid, mem_req}, 0);
    chk(rx_n < 200 && n_txf == 0, "R11 frame cut short", rx_n, 0);
    chk(dmem[32'h40 >> 2][31], "R11 no write-back after abort", dmem[32'h40 >> 2][31], 1);
    clr(); go(); repeat (5) @(negedge clk);
    chk(mem_cnt == 0, "R11 reset write clears enable", mem_cnt, 0);
    ctrl(2'b10);
    clr(); go(); wait_idle();
    chk(first_head == 32'h40, "R10 pointer kept across abort", first_head, 32'h40);
    chk(rx_n == 200 && n_txf == 1, "R11 restart sends whole frame", rx_n, 200);
    chk_bytes(0, 32'h8000, 200, 1'b1, "R11 restarted frame data");
    tstall = 1'b0;

    chk(hold_bad == 0, "R12 stream held under back-pressure", hold_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule